// File: doc/BRIEF.md
# PSRAM Burst Latency Controller

This block sequences read and write bursts to an external pseudo-static RAM. The RAM shares one 16-bit bus between address and data. A host issues one request at a time. Each request carries a direction, a start address and a burst length. The block then drives the memory strobes and moves the data beats. It fills in one host write word per write beat, and it returns one read word per read beat, marked by a one-cycle valid.

The block has two ways of timing the first beat. In fixed latency mode, a two-bit wait-state code and a half-step modifier bit set a clock count. This count delays only the first beat, and every later beat of the burst takes one cycle. In variable latency mode, the memory's ready input paces the transfer. A low ready holds off the start while the memory refreshes, sets the initial latency, and stretches the burst when a refresh collides with it mid-way. An optional one-cycle delay on the ready input lets the block follow memories that signal ready one clock early. All configuration inputs are captured when a request is accepted.

Top module: `psram_burst_ctrl`

## Requirements
- R1: While reset is active and after its release, the block is idle: chip select, address strobe, output enable and write enable are all high, rd_valid and wr_take are 0, and req_ready is 1.
- R2: In the cycle after a request is accepted, chip select goes low and the address strobe goes low for exactly that one cycle, with mem_ad_oe at 1 and mem_ad_out equal to the zero-extended request address. Chip select never falls without the address strobe.
- R3: In fixed latency mode (cfg_var_lat=0), the first data beat occurs L cycles after the address cycle. L = 3 + 2*cfg_ws - cfg_wsm when cfg_ws is not 0, and L = 3 when cfg_ws is 0 (the modifier is then ignored). This gives 3, 4, 5, 6, 7 and 9 clocks for (ws,wsm) = (0,0), (1,1), (1,0), (2,1), (2,0) and (3,0).
- R4: In fixed latency mode, a burst moves req_len+1 beats on consecutive cycles after the first, and mem_rdy has no effect on the timing.
- R5: In variable latency mode (cfg_var_lat=1), cfg_ws and cfg_wsm are ignored. From the cycle after the address cycle, one beat occurs in every cycle in which the effective ready is 1, until req_len+1 beats are done. Cycles with effective ready 0 add no beat, which covers refresh hold-off at the start and stalls mid-burst.
- R6: With cfg_rdy_dly=0 the effective ready is mem_rdy in the same cycle. With cfg_rdy_dly=1 it is the value mem_rdy had in the previous cycle.
- R7: For a read, mem_oe_n is low and mem_we_n is high from the cycle after the address cycle through the last beat, and mem_ad_oe is 0. rd_valid is 1 in the cycle after each beat, and rd_data is then the mem_ad_in value seen in the beat cycle.
- R8: For a write, mem_we_n is low and mem_ad_oe is 1 from the cycle after the address cycle through the last beat. wr_take is 1 in exactly the beat cycles, and mem_ad_out equals wr_data in those cycles.
- R9: Chip select stays low from the address cycle through the last beat. It is high for at least one cycle before the next access. req_ready is 1 only while idle, with chip select high.
- R10: Mode, wait-state code, modifier and ready delay are captured at acceptance. Changing them during a burst does not alter that burst's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_var_lat | input | 1 | 1 = ready-paced latency, 0 = fixed latency |
| cfg_ws | input | 2 | Wait-state code for fixed latency |
| cfg_wsm | input | 1 | Half-step modifier; subtracts one clock when cfg_ws is not 0 |
| cfg_rdy_dly | input | 1 | 1 = use mem_rdy delayed by one cycle |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle; a request is accepted when both are 1 |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | 16 | Start address |
| req_len | input | 4 | Beats minus one |
| wr_data | input | 16 | Host word for the current write beat |
| wr_take | output | 1 | Current write word consumed at this clock edge |
| rd_valid | output | 1 | rd_data holds a returned read beat |
| rd_data | output | 16 | Returned read word |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_adv_n | output | 1 | Address-latch strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ad_out | output | 16 | Value driven onto the shared address/data bus |
| mem_ad_oe | output | 1 | Block drives the shared bus |
| mem_ad_in | input | 16 | Value sampled from the shared bus |
| mem_rdy | input | 1 | Memory ready, 1 = may transfer |

## Verification
The assertions check strobe relations on every cycle. The address strobe lasts one cycle and always opens a chip-select window. Output enable and write enable are never low together, and the bus is never driven while a read is in progress. Each read valid follows a cycle with output enable low, each write take falls inside an active write, and no variable-mode beat fires without effective ready. The exact latency counts for every wait-state code, the beat count, consecutive fixed-mode beats that ignore ready, the one-cycle ready delay, the data values and the capture of configuration at acceptance all depend on whole bursts. Only the bench's directed and random scenarios show these.

// File: rtl/psram_burst_pkg.sv
package psram_burst_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_WAIT = 2'd2,
      ST_XFER = 2'd3
   } psram_st_e;

   localparam int unsigned PSRAM_BASE_LAT = 3;
   localparam int unsigned PSRAM_MIN_WAIT = 2;

endpackage

// File: rtl/psram_lat_calc.sv
module psram_lat_calc
   import psram_burst_pkg::*;
#(
   parameter int WS_W  = 2,
   parameter int LAT_W = WS_W + 2
) (
   input  logic [WS_W-1:0]  ws,
   input  logic             wsm,
   output logic [LAT_W-1:0] wait_init
);

   logic [LAT_W-1:0] lat;
   logic             trim;

   always_comb begin
      trim      = wsm && (ws != '0);
      lat       = LAT_W'(PSRAM_BASE_LAT) + (LAT_W'(ws) << 1) - LAT_W'(trim);
      wait_init = lat - LAT_W'(PSRAM_MIN_WAIT);
   end

endmodule

// File: rtl/psram_rdy_sample.sv
module psram_rdy_sample #(
   parameter bit DLY_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rdy_in,
   input  logic dly_sel,
   output logic rdy_eff
);

   generate
      if (DLY_EN) begin : g_dly
         logic rdy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdy_q <= 1'b0;
            else        rdy_q <= rdy_in;
         end
         assign rdy_eff = dly_sel ? rdy_q : rdy_in;
      end else begin : g_direct
         logic unused_sel;
         assign unused_sel = ^{dly_sel, clk, rst_n};
         assign rdy_eff    = rdy_in;
      end
   endgenerate

endmodule

// File: rtl/psram_rd_capture.sv
module psram_rd_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [DATA_W-1:0] din,
   output logic              valid,
   output logic [DATA_W-1:0] dout
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else begin
         valid <= take;
         if (take) dout <= din;
      end
   end

endmodule

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl
   import psram_burst_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 16,
   parameter int LEN_W      = 4,
   parameter int WS_W       = 2,
   parameter bit RDY_DLY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_var_lat,
   input  logic [WS_W-1:0]   cfg_ws,
   input  logic              cfg_wsm,
   input  logic              cfg_rdy_dly,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_take,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              mem_cs_n,
   output logic              mem_adv_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_ad_out,
   output logic              mem_ad_oe,
   input  logic [DATA_W-1:0] mem_ad_in,
   input  logic              mem_rdy
);

   localparam int LAT_W = WS_W + 2;

   generate
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("psram_burst_ctrl: ADDR_W must not exceed DATA_W");
      end
      if (LEN_W < 1 || WS_W < 1) begin : g_bad_cnt
         $error("psram_burst_ctrl: LEN_W and WS_W must be at least 1");
      end
   endgenerate

   psram_st_e         st;
   logic              var_q;
   logic              write_q;
   logic              dly_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  bcnt_q;
   logic [LAT_W-1:0]  wcnt_q;
   logic [LAT_W-1:0]  wait_init;
   logic              rdy_eff;
   logic              beat_fire;
   logic              active;

   psram_lat_calc #(
      .WS_W  (WS_W),
      .LAT_W (LAT_W)
   ) u_lat (
      .ws        (cfg_ws),
      .wsm       (cfg_wsm),
      .wait_init (wait_init)
   );

   psram_rdy_sample #(
      .DLY_EN (RDY_DLY_EN)
   ) u_rdy (
      .clk     (clk),
      .rst_n   (rst_n),
      .rdy_in  (mem_rdy),
      .dly_sel (dly_q),
      .rdy_eff (rdy_eff)
   );

   assign beat_fire = (st == ST_XFER) && (!var_q || rdy_eff);
   assign active    = (st == ST_WAIT) || (st == ST_XFER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         var_q   <= 1'b0;
         write_q <= 1'b0;
         dly_q   <= 1'b0;
         addr_q  <= '0;
         bcnt_q  <= '0;
         wcnt_q  <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  st      <= ST_ADDR;
                  var_q   <= cfg_var_lat;
                  write_q <= req_write;
                  dly_q   <= cfg_rdy_dly;
                  addr_q  <= req_addr;
                  bcnt_q  <= req_len;
                  wcnt_q  <= wait_init;
               end
            end
            ST_ADDR: st <= var_q ? ST_XFER : ST_WAIT;
            ST_WAIT: begin
               if (wcnt_q == '0) st <= ST_XFER;
               else              wcnt_q <= wcnt_q - 1'b1;
            end
            ST_XFER: begin
               if (beat_fire) begin
                  if (bcnt_q == '0) st <= ST_IDLE;
                  else              bcnt_q <= bcnt_q - 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   psram_rd_capture #(
      .DATA_W (DATA_W)
   ) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (beat_fire && !write_q),
      .din   (mem_ad_in),
      .valid (rd_valid),
      .dout  (rd_data)
   );

   always_comb begin
      req_ready  = (st == ST_IDLE);
      mem_cs_n   = (st == ST_IDLE);
      mem_adv_n  = (st != ST_ADDR);
      mem_oe_n   = !(active && !write_q);
      mem_we_n   = !(active && write_q);
      mem_ad_oe  = (st == ST_ADDR) || (active && write_q);
      mem_ad_out = (st == ST_ADDR) ? DATA_W'(addr_q) : wr_data;
      wr_take    = beat_fire && write_q;
   end

endmodule

// File: rtl/psram_burst_ctrl_chk.sv
module psram_burst_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic wr_take,
   input logic rd_valid,
   input logic mem_cs_n,
   input logic mem_adv_n,
   input logic mem_oe_n,
   input logic mem_we_n,
   input logic mem_ad_oe,
   input logic beat_fire,
   input logic var_q,
   input logic rdy_eff
);

   assert_adv_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_adv_n |=> mem_adv_n);

   assert_cs_opens_with_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_cs_n) |-> !mem_adv_n);

   assert_ready_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> mem_cs_n);

   assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   assert_no_drive_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_ad_oe);

   assert_rd_valid_follows_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!mem_oe_n && !mem_cs_n));

   assert_take_in_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_take |-> (!mem_we_n && mem_ad_oe && !mem_cs_n));

   assert_var_beat_needs_rdy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_fire && var_q) |-> rdy_eff);

endmodule

bind psram_burst_ctrl psram_burst_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .wr_take   (wr_take),
   .rd_valid  (rd_valid),
   .mem_cs_n  (mem_cs_n),
   .mem_adv_n (mem_adv_n),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n),
   .mem_ad_oe (mem_ad_oe),
   .beat_fire (beat_fire),
   .var_q     (var_q),
   .rdy_eff   (rdy_eff)
);

// File: tb/psram_burst_ctrl_bench.sv
`timescale 1ns/1ps
module psram_burst_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_var_lat = 1'b0;
   logic [1:0]  cfg_ws = 2'd0;
   logic        cfg_wsm = 1'b0;
   logic        cfg_rdy_dly = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = 16'd0;
   logic [3:0]  req_len = 4'd0;
   logic [15:0] wr_data = 16'd0;
   logic        wr_take;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic        mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_ad_oe;
   logic [15:0] mem_ad_out;
   logic [15:0] mem_ad_in = 16'd0;
   logic        mem_rdy = 1'b0;

   int tests = 0;
   int fails = 0;
   int bid   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   psram_burst_ctrl u_psram_burst_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cfg_var_lat(cfg_var_lat), .cfg_ws(cfg_ws), .cfg_wsm(cfg_wsm), .cfg_rdy_dly(cfg_rdy_dly),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_len(req_len),
      .wr_data(wr_data), .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_ad_out(mem_ad_out), .mem_ad_oe(mem_ad_oe), .mem_ad_in(mem_ad_in), .mem_rdy(mem_rdy)
   );

   function automatic int exp_lat(input logic [1:0] ws, input logic wsm);
      if (ws == 2'd0) return 3;
      return 3 + 2 * int'(ws) - int'(wsm);
   endfunction

   function automatic logic [15:0] rd_word(input int k);
      return 16'((k * 40503) ^ (bid << 5) ^ 16'h1D2B);
   endfunction

   function automatic logic [15:0] wr_word(input int i);
      return 16'((i * 945) ^ (bid * 7) ^ 16'hC0DE);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s burst %0d: actual %0h expected %0h", req, what, bid, act, exp);
      end
   endtask

   // One burst: request, then per-cycle checks against a model built from the requirements.
   task automatic run_burst(input bit wr, input bit vmode, input logic [1:0] ws, input bit wsm,
                            input bit dly, input logic [15:0] addr, input logic [3:0] len,
                            input int rdy_pct, input int hold, input bit poke);
      int  n, lat, beats, widx, k;
      bit  rdy_now, rdy_prev, efire, prev_efire, eff, after;
      string rq;
      bid++;
      n = int'(len) + 1;
      lat = exp_lat(ws, wsm);
      beats = 0; widx = 0; rdy_prev = 1'b0; prev_efire = 1'b0; after = 1'b0;
      rq = vmode ? (dly ? "R6" : "R5") : "R3";
      @(negedge clk);
      cfg_var_lat = vmode; cfg_ws = ws; cfg_wsm = wsm; cfg_rdy_dly = dly;
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_len = len;
      mem_rdy = 1'b0;
      #1;
      check(req_ready == 1'b1 && mem_cs_n == 1'b1, "R9", "idle before request",
            {req_ready, mem_cs_n}, 2'b11);
      k = 0;
      while (k < 400) begin
         k++;
         @(negedge clk);
         req_valid = 1'b0;
         wr_data   = wr_word(widx);
         mem_ad_in = rd_word(k);
         rdy_now   = (k <= hold) ? 1'b0 : ($urandom_range(99) < rdy_pct);
         mem_rdy   = rdy_now;
         if (poke && k == 2) begin
            cfg_var_lat = ~vmode; cfg_ws = ~ws; cfg_wsm = ~wsm; cfg_rdy_dly = ~dly;
         end
         #1;
         if (after) begin
            check(mem_cs_n == 1'b1 && req_ready == 1'b1, "R9", "cs high after burst",
                  {mem_cs_n, req_ready}, 2'b11);
            if (!wr) begin
               check(rd_valid == 1'b1, "R7", "rd_valid after last beat", rd_valid, 1);
               check(rd_data == rd_word(k - 1), "R7", "last read data", rd_data, rd_word(k - 1));
            end
            break;
         end
         if (k == 1) begin
            efire = 1'b0;
            check(mem_cs_n == 1'b0 && mem_adv_n == 1'b0 && mem_ad_oe == 1'b1, "R2",
                  "address cycle strobes", {mem_cs_n, mem_adv_n, mem_ad_oe}, 3'b001);
            check(mem_ad_out == addr, "R2", "address on bus", mem_ad_out, addr);
         end else begin
            if (!vmode) efire = (k >= lat + 1) && (beats < n);
            else begin
               eff   = dly ? rdy_prev : rdy_now;
               efire = eff && (beats < n);
            end
            check(mem_adv_n == 1'b1 && mem_cs_n == 1'b0, "R9", "cs held, adv released",
                  {mem_adv_n, mem_cs_n}, 2'b10);
            if (wr) begin
               check(mem_we_n == 1'b0 && mem_oe_n == 1'b1 && mem_ad_oe == 1'b1, "R8",
                     "write strobes", {mem_we_n, mem_oe_n, mem_ad_oe}, 3'b011);
               check(wr_take == efire, poke ? "R10" : (vmode ? rq : (beats > 0 ? "R4" : "R3")),
                     "write beat timing", wr_take, efire);
               if (wr_take) begin
                  check(mem_ad_out == wr_word(widx), "R8", "write data on bus",
                        mem_ad_out, wr_word(widx));
                  widx++;
               end
            end else begin
               check(mem_oe_n == 1'b0 && mem_we_n == 1'b1 && mem_ad_oe == 1'b0, "R7",
                     "read strobes", {mem_oe_n, mem_we_n, mem_ad_oe}, 3'b010);
               check(rd_valid == prev_efire, poke ? "R10" : rq, "read beat timing",
                     rd_valid, prev_efire);
               if (rd_valid && prev_efire)
                  check(rd_data == rd_word(k - 1), "R7", "read data", rd_data, rd_word(k - 1));
            end
         end
         if (efire) beats++;
         if (beats == n) after = 1'b1;
         rdy_prev   = rdy_now;
         prev_efire = efire;
      end
      check(after == 1'b1, "R4", "burst completed", after, 1);
      @(negedge clk);
      mem_rdy = 1'b0;
   endtask

   initial begin
      #1;
      check(mem_cs_n && mem_adv_n && mem_oe_n && mem_we_n && !rd_valid && !wr_take && req_ready,
            "R1", "state in reset",
            {mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, rd_valid, wr_take, req_ready}, 7'b1111001);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(mem_cs_n && mem_adv_n && mem_oe_n && mem_we_n && !rd_valid && !wr_take && req_ready,
            "R1", "idle after reset",
            {mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, rd_valid, wr_take, req_ready}, 7'b1111001);

      // R3: every latency code, fixed mode, both directions; R4: ready toggles randomly
      run_burst(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h1234, 4'd3, 50, 0, 1'b0);
      run_burst(1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 16'h0042, 4'd2, 50, 0, 1'b0);
      run_burst(1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 16'hBEEF, 4'd0, 50, 0, 1'b0);
      run_burst(1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 16'h8001, 4'd5, 50, 0, 1'b0);
      run_burst(1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 16'h7FFE, 4'd15, 50, 0, 1'b0);
      run_burst(1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 16'hFFFF, 4'd15, 50, 0, 1'b0);
      // R3: modifier ignored at code 0
      run_burst(1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 16'h0000, 4'd1, 50, 0, 1'b0);
      // R5: refresh hold-off at start, then random stalls
      run_burst(1'b0, 1'b1, 2'd3, 1'b1, 1'b0, 16'h5555, 4'd7, 100, 6, 1'b0);
      run_burst(1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 16'hAAAA, 4'd9, 40, 3, 1'b0);
      // R6: delayed ready sampling
      run_burst(1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 16'h0F0F, 4'd6, 100, 4, 1'b0);
      run_burst(1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 16'hF0F0, 4'd8, 55, 2, 1'b0);
      // R10: configuration changed mid-burst
      run_burst(1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 16'h2222, 4'd4, 50, 0, 1'b1);
      run_burst(1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 16'h3333, 4'd4, 60, 2, 1'b1);
      run_burst(1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 16'h4444, 4'd3, 60, 1, 1'b1);

      void'($urandom(32'd20240611));
      for (int i = 0; i < 60; i++) begin
         logic [1:0] rws;
         bit         rwsm;
         rws  = 2'($urandom_range(3));
         rwsm = 1'($urandom_range(1));
         run_burst(1'($urandom_range(1)), 1'($urandom_range(1)), rws, rwsm,
                   1'($urandom_range(1)), 16'($urandom), 4'($urandom_range(15)),
                   30 + $urandom_range(70), $urandom_range(4), 1'b0);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(10 * 150000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL R9 watchdog expired: finished %0d expected %0d", done, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule